// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state for a small peripheral that has three kinds of source: a shift register and two timers. Each source pulses one bit for one cycle to flag an event. The flags sit in a 7-bit pending register. A 7-bit mask register selects which pending events may reach the processor. A single registered, active-high request line is formed from the pending and mask registers.

Software reaches both registers over a byte-wide register bus. The bus has separate select lines for the pending register and the mask register, plus a read strobe and a write strobe. The neighbouring logic also supplies three side-effect strobes. These clear flags when the shift-data register is read or when a timer register is accessed. The timers, the shift register and the rest of the address decode live outside this block.

Top module: `irq_flag_enable`

## Requirements
- R1: A one-cycle pulse on `src_set[i]` sets pending flag i at the next clock edge. The shift-done source is bit 2, shift data is bit 3, shift clock is bit 4, timer 2 is bit 5 and timer 1 is bit 6.
- R2: `irq` is a register. It goes high one clock edge after the pending and mask registers both hold a 1 in bit 2, 5 or 6. It drops one edge after no such bit remains.
- R3: Pending bits 0, 1, 3 and 4 never raise `irq`, even when their mask bits are set.
- R4: A bus write to the pending register (`sel_flag`) clears each flag whose written data bit (6:0) is 1. Flags written with 0 are unchanged.
- R5: A bus write to the mask register (`sel_enable`) with data bit 7 = 1 sets every mask bit whose data bit (6:0) is 1. Other mask bits are unchanged.
- R6: A mask write with data bit 7 = 0 clears every mask bit whose data bit (6:0) is 1. Other mask bits are unchanged.
- R7: A pending-register read returns the flags in bits 6:0. Bit 7 is 1 when any of the seven flags is also masked in, whatever its position.
- R8: A mask-register read returns the mask in bits 6:0, with bit 7 always 1.
- R9: A pulse on `shift_rd_clr` clears flags 2, 3 and 4 and leaves the others unchanged.
- R10: A pulse on `t1_clr` clears flag 6 only. A pulse on `t2_clr` clears flag 5 only.
- R11: When a set pulse and any clear (bus write or strobe) hit the same flag in the same cycle, the flag ends up set.
- R12: Reset clears every flag, every mask bit and `irq`.
- R13: `bus_rdata` is 0 whenever `bus_rd` is low. If both selects are high during a read, the pending register is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 7 | One-cycle set pulses from the sources, one per flag bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| sel_flag | input | 1 | Selects the pending register |
| sel_enable | input | 1 | Selects the mask register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| shift_rd_clr | input | 1 | Shift-data read occurred: clear flags 2 to 4 |
| t1_clr | input | 1 | Timer-1 access side effect: clear flag 6 |
| t2_clr | input | 1 | Timer-2 access side effect: clear flag 5 |
| irq | output | 1 | Registered interrupt request |

## Verification
Flag and mask updates land on the first clock edge after a stimulus. They are therefore visible through a combinational read at the next falling edge. `irq` is one register further on, so it is due on the second edge. Every check on `irq` looks at it both one falling edge after the stimulus, where it must still hold its old value, and one edge later, where it must show the new value. Register reads are sampled just after a falling edge, when all inputs are already stable.

// File: rtl/irq_flag_enable.sv
module irq_flag_enable #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] src_set,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             sel_flag,
  input  logic             sel_enable,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             shift_rd_clr,
  input  logic             t1_clr,
  input  logic             t2_clr,
  output logic             irq
);

  localparam logic [NBITS-1:0] IRQ_SRC   = NBITS'(7'b110_0100);
  localparam logic [NBITS-1:0] SHIFT_SRC = NBITS'(7'b001_1100);
  localparam logic [NBITS-1:0] T1_SRC    = NBITS'(7'b100_0000);
  localparam logic [NBITS-1:0] T2_SRC    = NBITS'(7'b010_0000);

  logic [NBITS-1:0] flag_q, en_q, clr_mask, wmask;
  logic             pend_any;

  assign wmask    = bus_wdata[NBITS-1:0];
  assign clr_mask = ({NBITS{bus_wr & sel_flag}} & wmask)
                  | ({NBITS{shift_rd_clr}} & SHIFT_SRC)
                  | ({NBITS{t1_clr}} & T1_SRC)
                  | ({NBITS{t2_clr}} & T2_SRC);
  assign pend_any = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | src_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     en_q <= '0;
    else if (bus_wr && sel_enable)  en_q <= bus_wdata[7] ? (en_q | wmask) : (en_q & ~wmask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_q & en_q & IRQ_SRC);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_flag)        bus_rdata = {pend_any, flag_q};
      else if (sel_enable) bus_rdata = {1'b1, en_q};
    end
  end

endmodule

// File: rtl/irq_flag_enable_chk.sv
module irq_flag_enable_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] src_set,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       sel_flag,
  input logic       sel_enable,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       shift_rd_clr,
  input logic [6:0] flag_q,
  input logic [6:0] en_q,
  input logic       irq
);

  // R11
  src_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  // R4
  flag_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_flag) |=> ((flag_q & $past(bus_wdata[6:0] & ~src_set)) == 7'd0));

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_enable && bus_wdata[7]) |=>
      ((en_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_enable && !bus_wdata[7]) |=> ((en_q & $past(bus_wdata[6:0])) == 7'd0));

  // R9
  shift_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rd_clr && src_set[4:2] == 3'd0) |=> (flag_q[4:2] == 3'd0));

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[6] == 1'b0 && en_q[5] == 1'b0 && en_q[2] == 1'b0) |=> !irq);

  // R8
  en_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_enable && !sel_flag) |-> bus_rdata[7]);

  // R13
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'd0));

endmodule

bind irq_flag_enable irq_flag_enable_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_set(src_set), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .sel_flag(sel_flag), .sel_enable(sel_enable), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .shift_rd_clr(shift_rd_clr), .flag_q(flag_q),
  .en_q(en_q), .irq(irq)
);

// File: tb/sim_irq_flag_enable.sv
`timescale 1ns/1ps
module sim_irq_flag_enable;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_set = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, sel_flag = 1'b0, sel_enable = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       shift_rd_clr = 1'b0, t1_clr = 1'b0, t2_clr = 1'b0;
  logic       irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_enable u0 (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .sel_flag(sel_flag), .sel_enable(sel_enable), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .shift_rd_clr(shift_rd_clr), .t1_clr(t1_clr),
    .t2_clr(t2_clr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] s, input logic w, input logic sf, input logic se,
                       input logic [7:0] d, input logic sh, input logic a1, input logic a2);
    src_set = s; bus_wr = w; sel_flag = sf; sel_enable = se; bus_wdata = d;
    shift_rd_clr = sh; t1_clr = a1; t2_clr = a2;
    @(negedge clk);
    src_set = '0; bus_wr = 0; sel_flag = 0; sel_enable = 0; bus_wdata = '0;
    shift_rd_clr = 0; t1_clr = 0; t2_clr = 0;
  endtask

  task automatic rd(input logic sf, input logic se, output logic [7:0] v);
    bus_rd = 1; sel_flag = sf; sel_enable = se;
    #0.5 v = bus_rdata;
    bus_rd = 0; sel_flag = 0; sel_enable = 0;
    #0.1;
  endtask

  task automatic wr_flag(input logic [7:0] d); drive('0, 1, 1, 0, d, 0, 0, 0); endtask
  task automatic wr_en(input logic [7:0] d);   drive('0, 1, 0, 1, d, 0, 0, 0); endtask
  task automatic pulse(input logic [6:0] s);    drive(s, 0, 0, 0, 8'h00, 0, 0, 0); endtask
  task automatic clean(); wr_flag(8'h7F); wr_en(8'h7F); @(negedge clk); endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1, 0, v); chk("R12 flags after reset", v, 8'h00);
    rd(0, 1, v); chk("R12/R8 mask after reset", v, 8'h80);
    chk("R12 irq after reset", {7'd0, irq}, 8'h00);
    chk("R13 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_positions();
    logic [7:0] v;
    clean();
    for (int b = 2; b <= 6; b++) begin
      pulse(7'(1 << b));
      rd(1, 0, v); chk("R1 source sets its bit", v, 8'(1 << b));
      wr_flag(8'(1 << b));
      rd(1, 0, v); chk("R4 single-bit clear", v, 8'h00);
    end
  endtask

  task automatic t_enable_rw();
    logic [7:0] v;
    clean();
    wr_en(8'hC4);
    rd(0, 1, v); chk("R5 mask set", v, 8'hC4);
    wr_en(8'h81);
    rd(0, 1, v); chk("R5 mask set keeps others", v, 8'hC5);
    wr_en(8'h04);
    rd(0, 1, v); chk("R6 mask clear", v, 8'hC1);
    rd(1, 1, v); chk("R13 both selects return flags", v, 8'h00);
  endtask

  task automatic t_irq_timing();
    clean();
    wr_en(8'hC0);
    pulse(7'h40);
    chk("R2 irq not yet after set", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R2 irq one edge after flag", {7'd0, irq}, 8'h01);
    wr_flag(8'h40);
    chk("R2 irq holds one edge", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R2 irq drops", {7'd0, irq}, 8'h00);
    wr_en(8'hA4);
    pulse(7'h04); @(negedge clk);
    chk("R2 irq from shift-done", {7'd0, irq}, 8'h01);
    wr_en(8'h04); @(negedge clk);
    chk("R2 irq drops on mask clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    clean();
    wr_en(8'h9B);
    pulse(7'h1B);
    repeat (3) @(negedge clk);
    chk("R3 non-request bits keep irq low", {7'd0, irq}, 8'h00);
    rd(1, 0, v); chk("R7 summary bit from any bit", v, 8'h9B);
    wr_en(8'h1B);
    rd(1, 0, v); chk("R7 summary clear when unmasked", v, 8'h1B);
  endtask

  task automatic t_partial_clear();
    logic [7:0] v;
    clean();
    pulse(7'h7C);
    wr_flag(8'h24);
    rd(1, 0, v); chk("R4 partial clear", v, 8'h58);
  endtask

  task automatic t_side_clears();
    logic [7:0] v;
    clean();
    pulse(7'h7F);
    drive('0, 0, 0, 0, 8'h00, 1, 0, 0);
    rd(1, 0, v); chk("R9 shift read clear", v, 8'h63);
    drive('0, 0, 0, 0, 8'h00, 0, 1, 0);
    rd(1, 0, v); chk("R10 timer-1 clear", v, 8'h23);
    drive('0, 0, 0, 0, 8'h00, 0, 0, 1);
    rd(1, 0, v); chk("R10 timer-2 clear", v, 8'h03);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    clean();
    pulse(7'h7F);
    drive(7'h44, 1, 1, 0, 8'h7F, 1, 1, 1);
    rd(1, 0, v); chk("R11 set beats clear", v, 8'h44);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_positions();
    t_enable_rw();
    t_irq_timing();
    t_masked();
    t_partial_clear();
    t_side_clears();
    t_set_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule